// File: doc/BRIEF.md
# Multi-Channel Pulse Rise/Fall Tracker

This block follows up to four concurrent pulses through a stream of spectral frames. On every frame strobe it receives a small set of peak slots from an upstream peak picker. Each slot carries a valid bit, a frequency-bin index and a power. A free tracker latches onto a bin when a peak first shows up there, which is the rising edge. It keeps following that bin while the bin keeps reappearing. It releases the bin on the first frame where the bin is missing, which is the falling edge.

A 16-bit frame counter timestamps both edges. When a tracker releases its bin, it emits a one-cycle report for that tracker. The report holds the bin, the rise frame and the fall frame, and the coarse width in frames. It also holds the power at the rise, the power in the last frame the bin was present, and the largest power seen in between. The width is a frame count. A downstream stage multiplies it by the frame duration to get time.

Top module: `pulse_tracker`

## Requirements
- R1: A synchronous active-high reset closes every tracker, clears all report strobes and sets the frame counter to 0. The first frame strobe after reset has index 0.
- R2: A peak slot can open a tracker only if it is valid and its bin lies in the range 3 to 17 inclusive. Bins 2 and 18 never open a tracker.
- R3: A bin that an open tracker already owns never opens a second tracker. When several slots in one frame carry the same unowned bin, that bin opens one tracker only. No two open trackers ever hold the same bin.
- R4: Eligible new bins are taken in slot order, slot 0 first. Each one goes to the lowest-numbered tracker that was closed at the start of the frame. A tracker that closes in a frame cannot reopen in that same frame. Bins left over when no tracker is free are dropped.
- R5: An open tracker stays open for every frame in which some valid slot carries its bin. The power of the lowest-numbered such slot is the bin's power for that frame. The stored maximum power is replaced whenever this power is larger than it.
- R6: An open tracker closes on the first frame in which no valid slot carries its bin. In the cycle after that frame strobe, rpt_vld goes high for that tracker for exactly one cycle. Alongside it the report outputs give:
  - the bin;
  - the rise frame index and the fall frame index, where the fall frame is the first frame without the bin;
  - the power at the rise;
  - the power in the last frame the bin was present;
  - the maximum power.
- R7: The frame counter is 16 bits wide and wraps from 65535 to 0. The reported width is (fall - rise) modulo 65536, which is the number of frames in which the pulse was present.
- R8: Peak slots presented while frm_vld is low have no effect. They open no tracker, close none, and do not advance the frame counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_vld | input | 1 | Frame strobe; the peak slots are read in this cycle |
| pk_vld | input | 4 | Valid bit per peak slot (bit i = slot i) |
| pk_bin | input | 24 | Bin per slot, slot i at bits [6i+5:6i] |
| pk_pwr | input | 64 | Power per slot, slot i at bits [16i+15:16i] |
| trk_open | output | 4 | Rise flag per tracker |
| rpt_vld | output | 4 | One-cycle report strobe per tracker |
| rpt_bin | output | 24 | Reported bin, tracker t at bits [6t+5:6t] |
| rpt_rise | output | 64 | Rise frame index, tracker t at [16t+15:16t] |
| rpt_fall | output | 64 | Fall frame index, tracker t at [16t+15:16t] |
| rpt_width | output | 64 | Width in frames, tracker t at [16t+15:16t] |
| rpt_prise | output | 64 | Power at the rise, tracker t at [16t+15:16t] |
| rpt_pfall | output | 64 | Power in the last present frame, tracker t at [16t+15:16t] |
| rpt_pmax | output | 64 | Largest power while open, tracker t at [16t+15:16t] |

## Verification
The bench uses the default parameters: four trackers, four peak slots, 6-bit bins and 16-bit frame and power fields. With four slots a single frame can offer more new bins than there are free trackers. It can also offer duplicate bins and out-of-range bins alongside owned ones. These cases exercise the slot-order and lowest-tracker assignment rules and the ownership check. The 16-bit frame counter is small enough that a pulse straddling the wrap from 65535 to 0 can be reached by streaming empty frames. That case shows the modulo width.

// File: rtl/pulse_tracker.sv
module pulse_tracker #(
  parameter int NTRK   = 4,
  parameter int NPK    = 4,
  parameter int BW     = 6,
  parameter int FW     = 16,
  parameter int PW     = 16,
  parameter int BIN_LO = 3,
  parameter int BIN_HI = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_vld,
  input  logic [NPK-1:0]     pk_vld,
  input  logic [NPK*BW-1:0]  pk_bin,
  input  logic [NPK*PW-1:0]  pk_pwr,
  output logic [NTRK-1:0]    trk_open,
  output logic [NTRK-1:0]    rpt_vld,
  output logic [NTRK*BW-1:0] rpt_bin,
  output logic [NTRK*FW-1:0] rpt_rise,
  output logic [NTRK*FW-1:0] rpt_fall,
  output logic [NTRK*FW-1:0] rpt_width,
  output logic [NTRK*PW-1:0] rpt_prise,
  output logic [NTRK*PW-1:0] rpt_pfall,
  output logic [NTRK*PW-1:0] rpt_pmax
);
  localparam logic [BW-1:0] LO_B = BW'(BIN_LO);
  localparam logic [BW-1:0] HI_B = BW'(BIN_HI);

  logic [NTRK-1:0] open_q;
  logic [BW-1:0]   bin_q   [NTRK];
  logic [FW-1:0]   rise_q  [NTRK];
  logic [PW-1:0]   prise_q [NTRK];
  logic [PW-1:0]   pmax_q  [NTRK];
  logic [PW-1:0]   plast_q [NTRK];
  logic [FW-1:0]   fcnt;

  logic [NTRK-1:0] hit, take;
  logic [PW-1:0]   hpwr [NTRK];
  logic [BW-1:0]   nbin [NTRK];
  logic [PW-1:0]   npwr [NTRK];

  assign trk_open = open_q;

  always_comb begin
    logic elig, done;
    logic [BW-1:0] b, bq;
    for (int t = 0; t < NTRK; t++) begin
      hit[t] = 1'b0;
      hpwr[t] = '0;
      take[t] = 1'b0;
      nbin[t] = '0;
      npwr[t] = '0;
      for (int p = 0; p < NPK; p++)
        if (!hit[t] && open_q[t] && pk_vld[p] && pk_bin[p*BW +: BW] == bin_q[t]) begin
          hit[t] = 1'b1;
          hpwr[t] = pk_pwr[p*PW +: PW];
        end
    end
    for (int p = 0; p < NPK; p++) begin
      b = pk_bin[p*BW +: BW];
      elig = pk_vld[p] && b >= LO_B && b <= HI_B;
      for (int t = 0; t < NTRK; t++)
        if (open_q[t] && bin_q[t] == b) elig = 1'b0;
      for (int q = 0; q < NPK; q++) begin
        bq = pk_bin[q*BW +: BW];
        if (q < p && pk_vld[q] && bq == b) elig = 1'b0;
      end
      done = !elig;
      for (int t = 0; t < NTRK; t++)
        if (!done && !open_q[t] && !take[t]) begin
          take[t] = 1'b1;
          nbin[t] = b;
          npwr[t] = pk_pwr[p*PW +: PW];
          done = 1'b1;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= '0;
      rpt_vld <= '0;
      fcnt    <= '0;
      for (int t = 0; t < NTRK; t++) begin
        bin_q[t]   <= '0;
        rise_q[t]  <= '0;
        prise_q[t] <= '0;
        pmax_q[t]  <= '0;
        plast_q[t] <= '0;
      end
    end else begin
      rpt_vld <= '0;
      if (frm_vld) begin
        fcnt <= fcnt + 1'b1;
        for (int t = 0; t < NTRK; t++) begin
          if (open_q[t]) begin
            if (hit[t]) begin
              plast_q[t] <= hpwr[t];
              if (hpwr[t] > pmax_q[t]) pmax_q[t] <= hpwr[t];
            end else begin
              open_q[t]  <= 1'b0;
              rpt_vld[t] <= 1'b1;
              rpt_bin[t*BW +: BW]   <= bin_q[t];
              rpt_rise[t*FW +: FW]  <= rise_q[t];
              rpt_fall[t*FW +: FW]  <= fcnt;
              rpt_width[t*FW +: FW] <= fcnt - rise_q[t];
              rpt_prise[t*PW +: PW] <= prise_q[t];
              rpt_pfall[t*PW +: PW] <= plast_q[t];
              rpt_pmax[t*PW +: PW]  <= pmax_q[t];
            end
          end else if (take[t]) begin
            open_q[t]  <= 1'b1;
            bin_q[t]   <= nbin[t];
            rise_q[t]  <= fcnt;
            prise_q[t] <= npwr[t];
            pmax_q[t]  <= npwr[t];
            plast_q[t] <= npwr[t];
          end
        end
      end
    end
  end

  AST_REPORT_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    (rpt_vld != '0) |-> $past(frm_vld)); // R6
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !frm_vld |=> $stable(open_q)); // R8

  for (genvar i = 0; i < NTRK; i++) begin : g_chk
    AST_OPEN_BIN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      open_q[i] |-> (bin_q[i] >= LO_B && bin_q[i] <= HI_B)); // R2
    AST_MAX_NOT_BELOW_RISE: assert property (@(posedge clk) disable iff (rst)
      open_q[i] |-> pmax_q[i] >= prise_q[i]); // R5
    for (genvar j = i + 1; j < NTRK; j++) begin : g_pair
      AST_UNIQUE_OWNER: assert property (@(posedge clk) disable iff (rst)
        (open_q[i] && open_q[j]) |-> bin_q[i] != bin_q[j]); // R3
    end
  end
endmodule

// File: tb/pulse_tracker_test.sv
module pulse_tracker_test;
  logic clk = 0, rst = 1, frm_vld = 0;
  logic [3:0]  pk_vld = 0;
  logic [23:0] pk_bin = 0;
  logic [63:0] pk_pwr = 0;
  logic [3:0]  trk_open, rpt_vld;
  logic [23:0] rpt_bin;
  logic [63:0] rpt_rise, rpt_fall, rpt_width, rpt_prise, rpt_pfall, rpt_pmax;
  int nchk = 0, nbad = 0;
  bit finished = 0;

  pulse_tracker uut (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0] v;
    logic [7:0] b0, b1, b2, b3;
    logic [15:0] p0, p1, p2, p3;
    logic [3:0] eo, er;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{4'b0001,  8'd5, 8'd0,  8'd0,  8'd0,  16'd100, 16'd0,   16'd0,  16'd0,  4'b0001, 4'b0000},
    '{4'b0001,  8'd5, 8'd0,  8'd0,  8'd0,  16'd300, 16'd0,   16'd0,  16'd0,  4'b0001, 4'b0000},
    '{4'b0111,  8'd5, 8'd2,  8'd18, 8'd0,  16'd200, 16'd50,  16'd60, 16'd0,  4'b0001, 4'b0000},
    '{4'b1111,  8'd5, 8'd5,  8'd9,  8'd9,  16'd150, 16'd999, 16'd40, 16'd41, 4'b0011, 4'b0000},
    '{4'b0001,  8'd9, 8'd0,  8'd0,  8'd0,  16'd80,  16'd0,   16'd0,  16'd0,  4'b0010, 4'b0001},
    '{4'b1111,  8'd9, 8'd3,  8'd17, 8'd11, 16'd70,  16'd10,  16'd20, 16'd30, 4'b1111, 4'b0000},
    '{4'b1111,  8'd9, 8'd3,  8'd17, 8'd12, 16'd90,  16'd11,  16'd21, 16'd31, 4'b0111, 4'b1000},
    '{4'b1111,  8'd12, 8'd9, 8'd3,  8'd17, 16'd5,   16'd60,  16'd12, 16'd22, 4'b1111, 4'b0000},
    '{4'b0000,  8'd0, 8'd0,  8'd0,  8'd0,  16'd0,   16'd0,   16'd0,  16'd0,  4'b0000, 4'b1111}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(vec_t e);
    pk_vld = e.v;
    pk_bin = {e.b3[5:0], e.b2[5:0], e.b1[5:0], e.b0[5:0]};
    pk_pwr = {e.p3, e.p2, e.p1, e.p0};
    frm_vld = 1;
    @(negedge clk);
    frm_vld = 0;
    pk_vld = 0;
  endtask

  task automatic chk_rpt(string req, int t, int bin, int rise, int fall, int wid,
                         int prise, int pfall, int pmax);
    chk({req, " bin"},   rpt_bin[t*6 +: 6],     bin);
    chk({req, " rise"},  rpt_rise[t*16 +: 16],  rise);
    chk({req, " fall"},  rpt_fall[t*16 +: 16],  fall);
    chk({req, " width"}, rpt_width[t*16 +: 16], wid);
    chk({req, " prise"}, rpt_prise[t*16 +: 16], prise);
    chk({req, " pfall"}, rpt_pfall[t*16 +: 16], pfall);
    chk({req, " pmax"},  rpt_pmax[t*16 +: 16],  pmax);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  function automatic vec_t one(logic [7:0] b, logic [15:0] p);
    vec_t e = '0;
    e.v = 4'b0001; e.b0 = b; e.p0 = p;
    return e;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nchk++; nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 open after reset", trk_open, 0);
    chk("R1 rpt after reset", rpt_vld, 0);

    // R8 slots without frame strobe do nothing
    pk_vld = 4'b0001; pk_bin = 24'd7; pk_pwr = 64'd55;
    repeat (3) @(negedge clk);
    chk("R8 no open without strobe", trk_open, 0);
    pk_vld = 0;

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      frame(VEC[i]);
      chk($sformatf("R4 open mask step %0d", i), trk_open, VEC[i].eo);
      chk($sformatf("R6 report mask step %0d", i), rpt_vld, VEC[i].er);
      if (i == 4) chk_rpt("R6 R5 trk0", 0, 5, 0, 4, 4, 100, 150, 300);
      if (i == 6) chk_rpt("R6 trk3", 3, 11, 5, 6, 1, 30, 30, 30);
      if (i == 8) begin
        chk_rpt("R5 R3 trk1", 1, 9, 3, 8, 5, 40, 60, 90);
        chk_rpt("R4 trk3", 3, 12, 7, 8, 1, 5, 5, 5);
        chk_rpt("R2 trk2", 2, 17, 5, 8, 3, 20, 22, 22);
      end
      @(negedge clk);
      chk($sformatf("R6 strobe one cycle step %0d", i), rpt_vld, 0);
    end

    // R1 reset mid-pulse closes tracker, no report afterwards
    frame(one(8'd6, 16'd9));
    chk("R1 pre-reset open", trk_open, 4'b0001);
    do_reset();
    chk("R1 mid-pulse reset", trk_open, 0);
    frame('0);
    chk("R1 no report after reset", rpt_vld, 0);

    // R7 wrap: frame index restarts, pulse straddles 65535 -> 0
    do_reset();
    pk_vld = 0;
    frm_vld = 1;
    repeat (65534) @(negedge clk);
    frm_vld = 0;
    chk("R8 idle frames opened nothing", trk_open, 0);
    for (int k = 0; k < 4; k++) frame(one(8'd4, 16'(k + 1)));
    chk("R7 open across wrap", trk_open, 4'b0001);
    frame('0);
    chk("R7 report strobe", rpt_vld, 4'b0001);
    chk_rpt("R7 wrap", 0, 4, 65534, 2, 4, 1, 4, 4);

    // R2 boundary bins 2 and 18 alone
    frame(one(8'd2, 16'd1));
    chk("R2 bin 2 ignored", trk_open, 0);
    frame(one(8'd18, 16'd1));
    chk("R2 bin 18 ignored", trk_open, 0);
    frame(one(8'd3, 16'd1));
    chk("R2 bin 3 opens", trk_open, 4'b0001);

    finish_run();
  end
endmodule